// File: doc/BRIEF.md
# Audio DAC Framing Clock Generator

This block turns a reference clock into the two timing lines that frame serial audio for an external stereo DAC, and it drives the serial data line with them. A 14-bit sample-period value and a 4-bit bit-period value are written through simple write strobes. A down-counter, reloaded with half the sample period, paces a word clock that marks the left slot (high) and the right slot (low). A separate divider produces the bit clock. A bit-period value of zero freezes the block.

Once per word-clock period the block pulses a request for a new 32-bit stereo frame. The supplier answers with a one-cycle valid strobe. The frame that is held when the word clock rises is shifted out MSB first: its upper half goes out in the left slot and its lower half in the right slot. If no frame arrived in time, both slots carry zeros. The counter value and the two clock levels are packed into a status word at fixed bit positions, so a register-read neighbour can return it unchanged.

Top module: `audclk_gen`

## Requirements
- R1: While rst_n is low on a clock edge, every output is 0 after that edge: stat_word, dac_sdata and frame_req.
- R2: stat_word[14:1] holds the down-counter. While the bit-period register is nonzero, the counter steps down by one on each clock. When it is 0 it instead loads floor(P/2), where P is the sample-period register value at that edge.
- R3: The word clock (dac_wclk, also stat_word[19]) inverts on the edge after any cycle in which the block is running and the counter equals floor(H/2). H is the value of the latest reload, and it is 0 until the first reload. Each word-clock half period is therefore H+1 clocks, and its edges sit midway between counter reloads.
- R4: The bit clock (dac_bclk, also stat_word[16]) inverts every B+1 clocks, where B is the nonzero bit-period register value.
- R5: While the bit-period register is 0, the counter, word clock, bit clock and dac_sdata all hold their values.
- R6: frame_req is high for exactly one cycle: the first cycle in which the word clock is low after having been high.
- R7: A frame taken on frame_valid (frame_data, bit 31 as MSB) after a request and before the next word-clock rise is serialized with the first bit on dac_sdata from the word-clock edge onward. Bits 31..16 go out in the following high (left) slot and bits 15..0 in the next low (right) slot, MSB first. In each slot, the bit level present in the cycle the bit clock turns 1 gives the bits in order. dac_sdata changes only at a word-clock edge or a bit-clock falling edge, and only after the current bit has spanned one bit-clock rise.
- R8: If no frame was taken before a word-clock rise, both slots of that period are all zeros.
- R9: Every stat_word bit other than 19, 16 and 14:1 reads 0.
- R10: A sample-period write does not alter the counting pass in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one count per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_we | input | 1 | Write strobe for the sample-period register |
| rate_wdata | input | 14 | Sample-period value |
| bitper_we | input | 1 | Write strobe for the bit-period register |
| bitper_wdata | input | 4 | Bit-period value; 0 stops the block |
| frame_valid | input | 1 | One-cycle strobe: frame_data carries a stereo frame |
| frame_data | input | 32 | Stereo frame, left sample in the upper half |
| frame_req | output | 1 | One-cycle request for the next frame |
| dac_sdata | output | 1 | Serial audio data to the DAC |
| dac_bclk | output | 1 | Bit clock to the DAC |
| dac_wclk | output | 1 | Word clock to the DAC, 1 = left |
| stat_word | output | 32 | Status readback: counter at 14:1, bit clock at 16, word clock at 19 |

## Verification
A corrupted reload value or stale pass length shows up within one counter pass. It appears as a stat_word[14:1] sequence that breaks the step-down pattern, or as a word-clock edge at the wrong count, and the bench's per-cycle model reports it on the next clock. A fault in the serializer's pending or arming state shows up at the end of the affected 16-bit slot, where the scoreboard reads a shifted, repeated or non-zero word instead of the queued one. Freeze and bit-clock spacing faults are seen within one bit-clock half period.

// File: rtl/audclk_pkg.sv
// Shared sizes and status-word layout for the audio framing clock generator.
// Assumes the status word is 32 bits wide and the counter fits in bits 14:1.
package audclk_pkg;
    localparam int RATE_W       = 14;
    localparam int BITP_W       = 4;
    localparam int SLOT_W       = 16;
    localparam int STAT_W       = 32;
    localparam int STAT_CNT_LSB = 1;
    localparam int STAT_BCLK    = 16;
    localparam int STAT_WCLK    = 19;
endpackage

// File: rtl/audclk_rate_div.sv
// Sample-rate divider: a down-counter reloaded with half the sample period,
// plus the word clock, which toggles when the counter passes the midpoint
// of its current pass. Assumes `run` is low whenever the block is stopped.
// The wrise/wfall outputs are combinational and mark the edge on which
// wclk will change.
module audclk_rate_div #(
    parameter int RATE_W = audclk_pkg::RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic [RATE_W-1:0] count,
    output logic              wclk,
    output logic              wrise,
    output logic              wfall
);
    localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

    logic [RATE_W-1:0] hload;
    logic              wtog;

    // Midpoint detection of the pass in progress.
    always_comb begin
        wtog  = run && (count == (hload >> 1));
        wrise = wtog && !wclk;
        wfall = wtog && wclk;
    end

    // Counter: step down, reload with half the period at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            hload <= '0;
        end else if (run) begin
            if (count == '0) begin
                count <= rate >> 1;
                hload <= rate >> 1;
            end else begin
                count <= count - ONE;
            end
        end
    end

    // Word clock level.
    always_ff @(posedge clk) begin
        if (!rst_n)    wclk <= 1'b0;
        else if (wtog) wclk <= ~wclk;
    end
endmodule

// File: rtl/audclk_bit_div.sv
// Bit-clock divider: toggles bclk every (bitper+1) reference clocks.
// Assumes `run` is low when bitper is zero. brise/bfall are combinational
// and mark the edge on which bclk will change.
module audclk_bit_div #(
    parameter int BITP_W = audclk_pkg::BITP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BITP_W-1:0] bitper,
    output logic              bclk,
    output logic              brise,
    output logic              bfall
);
    localparam logic [BITP_W-1:0] ONE = BITP_W'(1);

    logic [BITP_W-1:0] bcnt;
    logic              btog;

    // Toggle request when the half-period count runs out.
    always_comb begin
        btog  = run && (bcnt == '0);
        brise = btog && !bclk;
        bfall = btog && bclk;
    end

    // Half-period counter and bit clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
            bclk <= 1'b0;
        end else if (btog) begin
            bcnt <= bitper;
            bclk <= ~bclk;
        end else if (run) begin
            bcnt <= bcnt - ONE;
        end
    end
endmodule

// File: rtl/audclk_serializer.sv
// Frame holder and slot serializer. A frame taken while the pending slot is
// empty is kept until the word clock rises. It then becomes the current
// frame: the upper half is loaded at the rise and the lower half at the fall.
// Bits leave MSB first on bit-clock falls, and each bit is held across one
// bit-clock rise before it may move. Assumes at most one frame per period.
module audclk_serializer #(
    parameter int SLOT_W = audclk_pkg::SLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wrise,
    input  logic                wfall,
    input  logic                brise,
    input  logic                bfall,
    input  logic                frame_valid,
    input  logic [2*SLOT_W-1:0] frame_data,
    output logic                frame_req,
    output logic                sdata
);
    localparam int FRAME_W = 2 * SLOT_W;

    logic [FRAME_W-1:0] pend;
    logic               pend_full;
    logic [FRAME_W-1:0] cur;
    logic [SLOT_W-1:0]  shreg;
    logic               armed;

    assign sdata = shreg[SLOT_W-1];

    // One-cycle request after the word clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_req <= 1'b0;
        else        frame_req <= wfall;
    end

    // Pending frame capture; emptied when the left slot starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            pend_full <= 1'b0;
        end else if (wrise) begin
            pend_full <= 1'b0;
        end else if (frame_valid && !pend_full) begin
            pend      <= frame_data;
            pend_full <= 1'b1;
        end
    end

    // Current frame, or silence if nothing was pending.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur <= '0;
        else if (wrise) cur <= pend_full ? pend : '0;
    end

    // Slot shift register with rise-before-shift arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            armed <= 1'b0;
        end else if (wrise) begin
            shreg <= pend_full ? pend[FRAME_W-1 -: SLOT_W] : '0;
            armed <= brise;
        end else if (wfall) begin
            shreg <= cur[SLOT_W-1:0];
            armed <= brise;
        end else if (brise) begin
            armed <= 1'b1;
        end else if (bfall && armed) begin
            shreg <= {shreg[SLOT_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/audclk_gen.sv
// Top of the audio framing clock generator. Holds the sample-period and
// bit-period registers, derives the run condition (bit period nonzero),
// joins the two dividers and the serializer, and packs the status word.
// Assumes register writes arrive as single-cycle strobes.
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int P_RATE_W = RATE_W,
    parameter int P_BITP_W = BITP_W,
    parameter int P_SLOT_W = SLOT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rate_we,
    input  logic [P_RATE_W-1:0]   rate_wdata,
    input  logic                  bitper_we,
    input  logic [P_BITP_W-1:0]   bitper_wdata,
    input  logic                  frame_valid,
    input  logic [2*P_SLOT_W-1:0] frame_data,
    output logic                  frame_req,
    output logic                  dac_sdata,
    output logic                  dac_bclk,
    output logic                  dac_wclk,
    output logic [STAT_W-1:0]     stat_word
);
    logic [P_RATE_W-1:0] rate_q;
    logic [P_BITP_W-1:0] bitper_q;
    logic [P_RATE_W-1:0] wcount;
    logic                run;
    logic                wrise, wfall, brise, bfall;

    assign run = (bitper_q != '0);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            bitper_q <= '0;
        end else begin
            if (rate_we)   rate_q   <= rate_wdata;
            if (bitper_we) bitper_q <= bitper_wdata;
        end
    end

    audclk_rate_div #(.RATE_W(P_RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(run), .rate(rate_q),
        .count(wcount), .wclk(dac_wclk), .wrise(wrise), .wfall(wfall)
    );

    audclk_bit_div #(.BITP_W(P_BITP_W)) u_bit (
        .clk(clk), .rst_n(rst_n), .run(run), .bitper(bitper_q),
        .bclk(dac_bclk), .brise(brise), .bfall(bfall)
    );

    audclk_serializer #(.SLOT_W(P_SLOT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .wrise(wrise), .wfall(wfall),
        .brise(brise), .bfall(bfall), .frame_valid(frame_valid),
        .frame_data(frame_data), .frame_req(frame_req), .sdata(dac_sdata)
    );

    // Status word packing at fixed positions.
    always_comb begin
        stat_word = '0;
        stat_word[STAT_CNT_LSB +: P_RATE_W] = wcount;
        stat_word[STAT_BCLK] = dac_bclk;
        stat_word[STAT_WCLK] = dac_wclk;
    end
endmodule

// File: rtl/audclk_gen_props.sv
// Property checker for audclk_gen, attached by the bind below. It observes
// the counter, the clocks, the request and the run condition.
module audclk_gen_props #(
    parameter int RATE_W = audclk_pkg::RATE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [RATE_W-1:0] rate_q,
    input logic [RATE_W-1:0] count,
    input logic              wclk,
    input logic              bclk,
    input logic              sdata,
    input logic              frame_req
);
    localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count != '0) |=> (count == $past(count) - ONE));

    a_r2_count_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == '0) |=> (count == ($past(rate_q) >> 1)));

    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(count) && $stable(wclk) && $stable(bclk) && $stable(sdata)));

    a_r4_bclk_only_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bclk) |-> $past(run));

    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req |=> !frame_req);

    a_r6_req_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req |-> ($past(wclk) && !wclk));

    a_r6_fall_gives_req: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wclk) && !wclk) |-> frame_req);
endmodule

bind audclk_gen audclk_gen_props #(.RATE_W(P_RATE_W)) u_props (
    .clk(clk), .rst_n(rst_n), .run(run), .rate_q(rate_q), .count(wcount),
    .wclk(dac_wclk), .bclk(dac_bclk), .sdata(dac_sdata), .frame_req(frame_req)
);

// File: tb/audclk_gen_test.sv
`timescale 1ns/100ps
// Scoreboard bench: the frame driver queues expected slot words, and the
// sampling process rebuilds slots from the DAC lines and compares them. It
// also runs a per-cycle model of counter, word clock, bit clock and request.
module audclk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_we = 1'b0;
    logic [13:0] rate_wdata = '0;
    logic        bitper_we = 1'b0;
    logic [3:0]  bitper_wdata = '0;
    logic        frame_valid = 1'b0;
    logic [31:0] frame_data = '0;
    logic        frame_req, dac_sdata, dac_bclk, dac_wclk;
    logic [31:0] stat_word;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    bit sb_on = 1'b0;
    bit model_on = 1'b0;
    int rate_sh = 0;
    int bp_sh = 0;
    logic [15:0] expq[$];

    always #2.5 clk = ~clk;

    audclk_gen uut (
        .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
        .bitper_we(bitper_we), .bitper_wdata(bitper_wdata),
        .frame_valid(frame_valid), .frame_data(frame_data),
        .frame_req(frame_req), .dac_sdata(dac_sdata), .dac_bclk(dac_bclk),
        .dac_wclk(dac_wclk), .stat_word(stat_word)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_rate(input int v);
        @(negedge clk); rate_we = 1'b1; rate_wdata = 14'(v);
        @(negedge clk); rate_we = 1'b0; rate_sh = v;
    endtask

    task automatic wr_bp(input int v);
        @(negedge clk); bitper_we = 1'b1; bitper_wdata = 4'(v);
        @(negedge clk); bitper_we = 1'b0; bp_sh = v;
    endtask

    // Per-cycle model and slot monitor, sampled 1 ns after each rising edge.
    initial begin
        int pc, pw, pb, psd, eh, ec, bint, pbp, nbits;
        bit etog, bvalid, coll;
        logic [15:0] word;
        pc = 0; pw = 0; pb = 0; psd = 0; eh = 0; bint = 0; pbp = 0;
        bvalid = 0; coll = 0; nbits = 0; word = '0;
        wait (model_on);
        forever begin
            int c, w, b, sd;
            @(posedge clk); #1;
            c = int'(stat_word[14:1]); w = int'(dac_wclk); b = int'(dac_bclk); sd = int'(dac_sdata);
            if (bp_sh != 0) begin
                ec = (pc == 0) ? (rate_sh >> 1) : pc - 1;
                etog = (pc == (eh >> 1));
                if (pc == 0) eh = rate_sh >> 1;
            end else begin
                ec = pc; etog = 0;
                chk(b == pb && sd == psd, "R5 bclk/sdata frozen", {b, sd}, {pb, psd});
            end
            chk(c == ec, "R2 counter", c, ec);
            chk((w != pw) == etog, "R3 word clock toggle", w, etog ? 1 - pw : pw);
            chk(frame_req == (pw == 1 && w == 0), "R6 frame_req", frame_req, (pw == 1 && w == 0));
            chk((stat_word & ~32'h0009_7FFE) == 0, "R9 unused status bits", stat_word, 0);
            // Bit clock spacing (R4).
            bint++;
            if (bp_sh != pbp) bvalid = 0;
            if (b != pb) begin
                if (bvalid) chk(bint == bp_sh + 1, "R4 bit clock half period", bint, bp_sh + 1);
                bint = 0; bvalid = 1;
            end
            pbp = bp_sh;
            // Slot reconstruction (R7, R8).
            if (sb_on) begin
                if (w != pw) begin coll = 1; nbits = 0; word = '0; end
                if (coll && b == 1 && pb == 0 && nbits < 16) begin
                    word = {word[14:0], dac_sdata};
                    nbits++;
                    if (nbits == 16 && expq.size() != 0) begin
                        logic [15:0] e;
                        e = expq.pop_front();
                        chk(word == e, "R7/R8 slot word", word, e);
                    end
                end
            end
            pc = c; pw = w; pb = b; psd = sd;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Driver.
    initial begin
        logic [31:0] snap;
        logic        snap_sd;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(stat_word == 0, "R1 status at reset", stat_word, 0);
        chk(dac_sdata == 0, "R1 sdata at reset", dac_sdata, 0);
        chk(frame_req == 0, "R1 frame_req at reset", frame_req, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        // First period has nothing pending: two silent slots (R8).
        sb_on = 1'b1;
        expq.push_back(16'h0000); expq.push_back(16'h0000);
        wr_rate(599);
        wr_bp(3);
        for (int f = 0; f < 6; f++) begin
            do begin @(posedge clk); #1; end while (!frame_req);
            repeat (5) @(negedge clk);
            if (f == 3) begin
                expq.push_back(16'h0000); expq.push_back(16'h0000); // R8 skipped frame
            end else begin
                logic [31:0] d;
                d = {16'h8001 + 16'(f) * 16'h1357, 16'h7FFE ^ (16'(f) * 16'h2469)};
                expq.push_back(d[31:16]); expq.push_back(d[15:0]);
                frame_valid = 1'b1; frame_data = d;
                @(negedge clk);
                frame_valid = 1'b0; frame_data = '0;
            end
        end
        while (expq.size() != 0) @(negedge clk);
        chk(expq.size() == 0, "R7 all queued slots emitted", expq.size(), 0);
        sb_on = 1'b0;
        // R10: a new period mid-pass; model checks the reload value.
        repeat (37) @(negedge clk);
        wr_rate(200);
        repeat (700) @(negedge clk);
        wr_bp(1);
        repeat (600) @(negedge clk);
        wr_rate(1);
        repeat (60) @(negedge clk);
        // R5: freeze.
        wr_bp(0);
        snap = stat_word; snap_sd = dac_sdata;
        repeat (40) @(negedge clk);
        chk(stat_word == snap, "R5 status frozen", stat_word, snap);
        chk(dac_sdata == snap_sd, "R5 sdata frozen", dac_sdata, snap_sd);
        wr_rate(999);
        wr_bp(15);
        repeat (800) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule